// File: doc/BRIEF.md
# Programmable Free-Running Clock Output Divider

This block derives two free-running clock outputs for export from a chip. The first is the bus clock divided by a programmable ratio: a 5-bit divider code chooses a ratio from 1 to 32, and an optional stage multiplies that ratio by 16. The second output is a double-rate clock. It is supplied on its own input and is only gated here. Each output has its own disable bit. Software sets all of this through a single 8-bit control register on a simple write/read port.

An emulation-mode input overrides the register. While it is high, both outputs run whatever their disable bits hold, and the divided output runs at the bus clock rate. Ratio and enable changes on the divided output take effect only at the end of a full output period. Both outputs are gated with latch-based clock gates, so no shortened pulse reaches a pin.

Top module: `clkdiv_out`

## Requirements
- R1: The control register resets to 0x00 and reads back all eight bits as last written.
- R2: With bit 5 clear, outside emulation, a code N in bits 4:0 gives a divided output period of N+1 bus clock cycles (code 0 passes the bus clock, code 31 divides by 32).
- R3: With bit 5 set, outside emulation, the period is 16*(N+1) bus clock cycles.
- R4: For a ratio R of 2 or more, the divided output is high for R-R/2 (rounded down) cycles and low for the rest; for R of 1 it is a copy of the bus clock.
- R5: Bit 7 set holds the divided output low outside emulation; bit 7 clear lets it run.
- R6: Bit 6 set holds the double-rate output low outside emulation; bit 6 clear passes the double-rate input clock.
- R7: With the emulation input high, both outputs run even if bits 7 and 6 are set.
- R8: With the emulation input high, the divided output runs at the bus clock rate whatever bits 5:0 hold.
- R9: A new ratio takes effect only after the output period in progress completes at its old length.
- R10: Disabling the divided output during a high phase does not shorten that high phase; the output stops at the next period boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk_i | input | 1 | Bus clock, source of the divided output |
| clk2x_i | input | 1 | Double-rate clock to be gated out |
| rst_ni | input | 1 | Asynchronous active-low reset |
| emu_i | input | 1 | Emulation-mode override |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Register write data |
| rd_data_o | output | 8 | Register read data |
| clk_div_o | output | 1 | Divided free-running clock |
| clk_x2_o | output | 1 | Gated double-rate clock |

## Verification
The divided output is timed edge to edge for every divider code with the /16 stage both off and on. This covers even and odd ratios, the bus clock pass-through at code 0, and the largest ratio of 512, so an off-by-one in the count or a wrong high/low split shows up as a period or high-time error. Writes that land mid-period tell apart a ratio applied at once from one applied at the boundary, and a disable during a high phase shows whether the pulse is truncated. Register value 0xFF with emulation low and then high tells apart the override from the disable bits and the divider settings.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
package clkdiv_pkg;
  localparam int CTRL_W    = 8;
  localparam int CODE_W    = 5;
  localparam int PRE_SHIFT = 4;   // /16 stage
  localparam int RATIO_W   = CODE_W + PRE_SHIFT + 1;
  localparam int BIT_DIVOFF = 7;
  localparam int BIT_X2OFF  = 6;
  localparam int BIT_PRE    = 5;
endpackage

// File: rtl/clkdiv_rst_sync.sv
`timescale 1ns/1ps
module clkdiv_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/clkdiv_icg.sv
`timescale 1ns/1ps
module clkdiv_icg (
  input  logic clk_i,
  input  logic en_i,
  output logic gclk_o
);
  logic en_lat;

  // enable captured only while the clock is low
  always_latch begin
    if (!clk_i) en_lat = en_i;
  end

  assign gclk_o = clk_i & en_lat;
endmodule

// File: rtl/clkdiv_core.sv
`timescale 1ns/1ps
module clkdiv_core #(
  parameter int CODE_W    = 5,
  parameter int PRE_SHIFT = 4,
  localparam int RATIO_W  = CODE_W + PRE_SHIFT + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [CODE_W-1:0]  code_i,
  input  logic               pre_en_i,
  input  logic               bypass_i,
  input  logic               en_req_i,
  output logic               div_q_o,
  output logic               pass_en_o,
  output logic [RATIO_W-1:0] cnt_o,
  output logic [RATIO_W-1:0] ratio_o,
  output logic               last_o
);
  localparam logic [RATIO_W-1:0] ONE = RATIO_W'(1);

  logic [RATIO_W-1:0] cnt_q, cnt_n;
  logic [RATIO_W-1:0] ratio_q, ratio_n, ratio_req, base, hi_n;
  logic               en_q, en_n, div_q, div_n, last;

  always_comb begin
    base      = RATIO_W'(code_i) + ONE;
    ratio_req = bypass_i ? ONE : (pre_en_i ? (base << PRE_SHIFT) : base);
    last      = (cnt_q == ratio_q - ONE);
    cnt_n     = last ? '0 : cnt_q + ONE;
    ratio_n   = last ? ratio_req : ratio_q;
    en_n      = last ? en_req_i  : en_q;
    hi_n      = ratio_n - (ratio_n >> 1);
    div_n     = en_n && (ratio_n != ONE) && (cnt_n < hi_n);
    pass_en_o = en_n && (ratio_n == ONE);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      ratio_q <= ONE;
      en_q    <= 1'b0;
      div_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_n;
      ratio_q <= ratio_n;
      en_q    <= en_n;
      div_q   <= div_n;
    end
  end

  assign div_q_o = div_q;
  assign cnt_o   = cnt_q;
  assign ratio_o = ratio_q;
  assign last_o  = last;
endmodule

// File: rtl/clkdiv_out.sv
`timescale 1ns/1ps
module clkdiv_out
  import clkdiv_pkg::*;
(
  input  logic              bus_clk_i,
  input  logic              clk2x_i,
  input  logic              rst_ni,
  input  logic              emu_i,
  input  logic              wr_en_i,
  input  logic [CTRL_W-1:0] wr_data_i,
  output logic [CTRL_W-1:0] rd_data_o,
  output logic              clk_div_o,
  output logic              clk_x2_o
);
  logic               rst_n;
  logic [CTRL_W-1:0]  ctrl_q, ctrl_n;
  logic               x2_en_q, x2_en_n;
  logic               div_q, pass_en, pass_gclk, cnt_last;
  logic [RATIO_W-1:0] cnt, ratio_act;

  clkdiv_rst_sync #(.STAGES(2)) u_rst (
    .clk_i(bus_clk_i), .rst_ni(rst_ni), .rst_no(rst_n)
  );

  always_comb begin
    ctrl_n  = wr_en_i ? wr_data_i : ctrl_q;
    x2_en_n = emu_i | ~ctrl_q[BIT_X2OFF];
  end

  always_ff @(posedge bus_clk_i or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      x2_en_q <= 1'b0;
    end else begin
      ctrl_q  <= ctrl_n;
      x2_en_q <= x2_en_n;
    end
  end

  clkdiv_core #(.CODE_W(CODE_W), .PRE_SHIFT(PRE_SHIFT)) u_core (
    .clk_i    (bus_clk_i),
    .rst_ni   (rst_n),
    .code_i   (ctrl_q[CODE_W-1:0]),
    .pre_en_i (ctrl_q[BIT_PRE]),
    .bypass_i (emu_i),
    .en_req_i (emu_i | ~ctrl_q[BIT_DIVOFF]),
    .div_q_o  (div_q),
    .pass_en_o(pass_en),
    .cnt_o    (cnt),
    .ratio_o  (ratio_act),
    .last_o   (cnt_last)
  );

  clkdiv_icg u_gate_bus (.clk_i(bus_clk_i), .en_i(pass_en), .gclk_o(pass_gclk));
  clkdiv_icg u_gate_x2  (.clk_i(clk2x_i),  .en_i(x2_en_q), .gclk_o(clk_x2_o));

  assign clk_div_o = div_q | pass_gclk;
  assign rd_data_o = ctrl_q;
endmodule

// File: rtl/clkdiv_out_chk.sv
`timescale 1ns/1ps
module clkdiv_out_chk
  import clkdiv_pkg::*;
(
  input logic               bus_clk_i,
  input logic               rst_n,
  input logic               emu_i,
  input logic               wr_en_i,
  input logic [CTRL_W-1:0]  wr_data_i,
  input logic [CTRL_W-1:0]  rd_data_o,
  input logic               cnt_last,
  input logic [RATIO_W-1:0] cnt,
  input logic [RATIO_W-1:0] ratio_act,
  input logic               div_q
);
  // R1: a write is visible on the read port in the next cycle
  a_r1_readback: assert property (@(posedge bus_clk_i) disable iff (!rst_n)
    wr_en_i |=> rd_data_o == $past(wr_data_i));

  // R2: the period counter never leaves the active ratio
  a_r2_cnt_range: assert property (@(posedge bus_clk_i) disable iff (!rst_n)
    cnt < ratio_act);

  // R9: the active ratio only changes at a period boundary
  a_r9_hold_ratio: assert property (@(posedge bus_clk_i) disable iff (!rst_n)
    !cnt_last |=> $stable(ratio_act));

  // R8: emulation at a boundary selects ratio one
  a_r8_emu_bypass: assert property (@(posedge bus_clk_i) disable iff (!rst_n)
    (emu_i && cnt_last) |=> ratio_act == RATIO_W'(1));

  // R10: the divided output is low at the last count of a period
  a_r10_low_at_boundary: assert property (@(posedge bus_clk_i) disable iff (!rst_n)
    (cnt_last && ratio_act != RATIO_W'(1)) |-> !div_q);
endmodule

bind clkdiv_out clkdiv_out_chk u_chk (
  .bus_clk_i(bus_clk_i), .rst_n(rst_n), .emu_i(emu_i), .wr_en_i(wr_en_i),
  .wr_data_i(wr_data_i), .rd_data_o(rd_data_o), .cnt_last(cnt_last),
  .cnt(cnt), .ratio_act(ratio_act), .div_q(div_q)
);

// File: tb/clkdiv_out_tb_top.sv
`timescale 1ns/1ps
module clkdiv_out_tb_top;
  localparam real TCLK = 5.0;

  logic       bus_clk = 1'b0;
  logic       clk2x   = 1'b0;
  logic       rst_n   = 1'b0;
  logic       emu     = 1'b0;
  logic       wr_en   = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       clk_div, clk_x2;

  int checks = 0, fails = 0;
  int div_rises = 0, x2_rises = 0;
  int done_cnt = 0;
  int exp_q[$];
  bit finished = 0;

  clkdiv_out dut_i (
    .bus_clk_i(bus_clk), .clk2x_i(clk2x), .rst_ni(rst_n), .emu_i(emu),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_data_o(rd_data),
    .clk_div_o(clk_div), .clk_x2_o(clk_x2)
  );

  // 200 MHz bus clock with an aligned 400 MHz double-rate clock
  initial forever begin
    #1.25 clk2x = ~clk2x;
    #1.25 clk2x = ~clk2x; bus_clk = ~bus_clk;
  end

  always @(posedge clk_div) div_rises++;
  always @(posedge clk_x2)  x2_rises++;

  function automatic bit close(real a, real b);
    return (a - b < 0.01) && (b - a < 0.01);
  endfunction

  task automatic check_int(string req, int act, int exp_lo, int exp_hi);
    checks++;
    if (act < exp_lo || act > exp_hi) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, exp_lo, exp_hi);
    end
  endtask

  task automatic check_real(string req, real act, real exp);
    checks++;
    if (!close(act, exp)) begin
      fails++;
      $display("FAIL %s actual=%0.2f expected=%0.2f", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge bus_clk); wr_en = 1'b1; wr_data = d;
    @(negedge bus_clk); wr_en = 1'b0;
  endtask

  // rising edges on both outputs over a window of bus cycles
  task automatic window(input int cyc, output int nd, output int nx);
    int d0, x0;
    @(negedge bus_clk); d0 = div_rises; x0 = x2_rises;
    repeat (cyc) @(negedge bus_clk);
    nd = div_rises - d0; nx = x2_rises - x0;
  endtask

  // scoreboard monitor: pops an expected ratio, times one full period
  initial begin
    forever begin
      int r; real t0, t1, t2, hi;
      wait (exp_q.size() > 0);
      r = exp_q.pop_front();
      @(posedge clk_div); t0 = $realtime;
      @(negedge clk_div); t1 = $realtime;
      @(posedge clk_div); t2 = $realtime;
      hi = (r == 1) ? TCLK / 2.0 : real'(r - r / 2) * TCLK;
      check_real($sformatf("R2/R3 period ratio=%0d", r), t2 - t0, real'(r) * TCLK);
      check_real($sformatf("R4 high time ratio=%0d", r), t1 - t0, hi);
      done_cnt++;
    end
  end

  task automatic expect_ratio(input int r);
    int target;
    target = done_cnt + 1;
    exp_q.push_back(r);
    wait (done_cnt == target);
  endtask

  initial begin
    int nd, nx, prev_r;
    real t0, t1;
    repeat (3) @(negedge bus_clk);
    rst_n = 1'b1;
    repeat (4) @(negedge bus_clk);

    check_int("R1 reset value", int'(rd_data), 0, 0);
    wr(8'hA5);
    check_int("R1 readback", int'(rd_data), 'hA5, 'hA5);

    // every code, /16 stage off then on
    prev_r = 96;
    for (int pre = 0; pre < 2; pre++) begin
      for (int code = 0; code < 32; code++) begin
        int r;
        r = (code + 1) * (pre ? 16 : 1);
        wr(8'((pre << 5) | code));
        repeat (2 * prev_r + 2 * r + 4) @(negedge bus_clk);
        expect_ratio(r);
        prev_r = r;
      end
    end

    // R9: ratio change mid-period
    wr(8'd19);
    repeat (2 * prev_r + 50) @(negedge bus_clk);
    @(posedge clk_div); t0 = $realtime;
    wr(8'd3);
    @(posedge clk_div); t1 = $realtime;
    check_real("R9 old period completes", t1 - t0, 20.0 * TCLK);
    @(posedge clk_div);
    check_real("R9 new period applied", $realtime - t1, 4.0 * TCLK);

    // R10 and R5: disable during a high phase
    wr(8'd19);
    repeat (60) @(negedge bus_clk);
    @(posedge clk_div); t0 = $realtime;
    wr(8'h80 | 8'd19);
    @(negedge clk_div);
    check_real("R10 high phase not cut", $realtime - t0, 10.0 * TCLK);
    repeat (25) @(negedge bus_clk);
    window(100, nd, nx);
    check_int("R5 divided output held low", nd, 0, 0);
    wr(8'd19);
    window(100, nd, nx);
    check_int("R5 divided output re-enabled", nd, 4, 6);

    // R6: double-rate output disabled then enabled
    wr(8'hFF);
    repeat (1100) @(negedge bus_clk);
    window(40, nd, nx);
    check_int("R6 double-rate held low", nx, 0, 0);
    check_int("R5 divided low with 0xFF", nd, 0, 0);

    // R7/R8: emulation overrides 0xFF
    @(negedge bus_clk); emu = 1'b1;
    repeat (1100) @(negedge bus_clk);
    window(40, nd, nx);
    check_int("R7 double-rate runs in emulation", nx, 79, 81);
    check_int("R7 divided runs in emulation", nd, 39, 41);
    expect_ratio(1); // R8: bus rate despite code 31 and /16
    check_int("R1 register kept in emulation", int'(rd_data), 'hFF, 'hFF);

    @(negedge bus_clk); emu = 1'b0;
    wr(8'h00);
    repeat (1100) @(negedge bus_clk);
    window(40, nd, nx);
    check_int("R6 double-rate enabled", nx, 79, 81);
    check_int("R2 bus-rate output after clear", nd, 39, 41);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000.0 * TCLK);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule